// File: doc/BRIEF.md
# Button Request Edge Latch

This block turns slow, held-down user buttons into one-shot request flags for a microcoded controller. Six button levels come in, already free of contact bounce: fast-forward, rewind, play, erase, record-greeting and ring. Each level is sampled on the rising clock edge. A low-to-high change between two samples makes a one-cycle pulse. That pulse sets a sticky request flag. The flag stays up after the button is let go, until the controller pulses the shared clear input.

The flags are captured on the falling edge of the same clock. This leaves half a cycle for the pulse from the rising-edge registers to settle, so no pulse can be missed. A button held for seconds gives exactly one request. The controller must then acknowledge it with the clear input before another press can be seen. If a new edge and the clear arrive together, the new edge wins.

Top module: `btn_req_latch`

## Requirements
- R1: A synchronous active-high `rst` clears every request flag at the next falling clock edge, and clears the sampling history at the next rising edge. A button held high through reset therefore counts as a fresh press: its flag is still 0 one cycle after `rst` falls and is 1 one cycle after that.
- R2: When a button's rising-edge sample is 1 and its previous sample was 0, its flag is set at the falling edge of that same cycle. A button driven high just after rising edge k shows its flag set when read just after rising edge k+2.
- R3: A button kept high yields one request only. Once the request is cleared, the flag stays 0 for as long as the button stays high.
- R4: With no clear and no new rising edge, a flag keeps its value, including after its button is released.
- R5: `req_clr` sampled high at a falling edge clears, at that edge, every flag that has no new rising edge in that cycle. A clear driven just after rising edge k reads as 0 just after rising edge k+1.
- R6: If a new rising edge and `req_clr` fall in the same cycle for one button, that button's flag ends up set.
- R7: The bits of `btn_lvl` and `req_flag` are laid out as bit 0 fast-forward, bit 1 rewind, bit 2 play, bit 3 erase, bit 4 record-greeting, bit 5 ring. Each channel acts on its own, with no effect on the others.
- R8: A high-to-low change of a button never sets its flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; rising edge samples buttons, falling edge captures flags |
| rst | input | 1 | Synchronous active-high reset |
| btn_lvl | input | N_BTN (6) | Button levels, one bit per button, mapped as in R7 |
| req_clr | input | 1 | Controller pulse that clears the request flags |
| req_flag | output | N_BTN (6) | Sticky request flags, same bit mapping as `btn_lvl` |

## Verification
The bench holds buttons high across several cycles and across a clear. A design that compared levels instead of edges would raise the flag again right after the clear. A press is timed to land in the same cycle as a clear; a design where clear wins would drop that press. Buttons are released with no clear pending and rising and falling edges are mixed across channels. This exposes a flag that is not sticky, one that fires on release, or one that leaks into a neighbour's bit. A button is also held through reset, which catches sampling history that is not cleared, or flags that come back before the first clean sample.

// File: rtl/btn_req_pkg.sv
`timescale 1ns/1ps
package btn_req_pkg;
  localparam int BTN_COUNT = 6;

  // bit positions of each button in the level and flag vectors
  localparam int IDX_FFWD  = 0;
  localparam int IDX_REW   = 1;
  localparam int IDX_PLAY  = 2;
  localparam int IDX_ERASE = 3;
  localparam int IDX_GREET = 4;
  localparam int IDX_RING  = 5;
endpackage

// File: rtl/btn_rise_detect.sv
`timescale 1ns/1ps
module btn_rise_detect #(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] cur_q;
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      cur_q  <= lvl_i;
      prev_q <= cur_q;
    end
  end

  generate
    for (genvar g = 0; g < WIDTH; g++) begin : g_rise
      assign rise_o[g] = cur_q[g] & ~prev_q[g];

      // R3: a pulse never lasts two cycles, so a held button gives one request
      p_pulse_single_r3 : assert property (@(posedge clk) disable iff (rst)
        rise_o[g] |=> !rise_o[g]);
    end
  endgenerate
endmodule

// File: rtl/req_flag_bank.sv
`timescale 1ns/1ps
module req_flag_bank #(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] set_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] flag_o
);
  logic [WIDTH-1:0] flag_q;

  generate
    for (genvar g = 0; g < WIDTH; g++) begin : g_flag
      // falling-edge capture: the rising-edge pulse has half a cycle to settle
      always_ff @(negedge clk) begin
        if (rst)           flag_q[g] <= 1'b0;
        else if (set_i[g]) flag_q[g] <= 1'b1;
        else if (clr_i)    flag_q[g] <= 1'b0;
      end

      // R2: a pulse is caught at this falling edge
      p_pulse_caught_r2 : assert property (@(negedge clk) disable iff (rst)
        set_i[g] |=> flag_q[g]);
      // R5: clear without a new edge drops the flag
      p_clear_drops_r5 : assert property (@(negedge clk) disable iff (rst)
        (clr_i && !set_i[g]) |=> !flag_q[g]);
      // R6: a new edge wins over a clear in the same cycle
      p_set_wins_r6 : assert property (@(negedge clk) disable iff (rst)
        (clr_i && set_i[g]) |=> flag_q[g]);
      // R4: nothing touching the flag leaves it unchanged
      p_flag_hold_r4 : assert property (@(negedge clk) disable iff (rst)
        (!clr_i && !set_i[g]) |=> $stable(flag_q[g]));
    end
  endgenerate

  // R1: reset empties the whole bank
  p_reset_clears_r1 : assert property (@(negedge clk)
    rst |=> (flag_q == '0));

  assign flag_o = flag_q;
endmodule

// File: rtl/btn_req_latch.sv
`timescale 1ns/1ps
module btn_req_latch
  import btn_req_pkg::*;
#(
  parameter int N_BTN = BTN_COUNT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_BTN-1:0] btn_lvl,
  input  logic             req_clr,
  output logic [N_BTN-1:0] req_flag
);
  logic [N_BTN-1:0] rise_w;

  btn_rise_detect #(.WIDTH(N_BTN)) u_rise (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (btn_lvl),
    .rise_o (rise_w)
  );

  req_flag_bank #(.WIDTH(N_BTN)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .set_i  (rise_w),
    .clr_i  (req_clr),
    .flag_o (req_flag)
  );
endmodule

// File: tb/btn_req_latch_tb.sv
`timescale 1ns/1ps
module btn_req_latch_tb_top;
  localparam int NB = 6;
  localparam int NV = 19;

  // each entry: {buttons applied, clear applied, flags expected one cycle later}
  localparam logic [12:0] VEC [0:NV-1] = '{
    {6'h01, 1'b0, 6'h00},
    {6'h01, 1'b0, 6'h01},
    {6'h01, 1'b0, 6'h01},
    {6'h00, 1'b0, 6'h01},
    {6'h00, 1'b1, 6'h00},
    {6'h01, 1'b0, 6'h00},
    {6'h06, 1'b0, 6'h01},
    {6'h06, 1'b0, 6'h07},
    {6'h00, 1'b1, 6'h00},
    {6'h38, 1'b0, 6'h00},
    {6'h38, 1'b1, 6'h38},
    {6'h3F, 1'b0, 6'h38},
    {6'h3F, 1'b1, 6'h07},
    {6'h00, 1'b0, 6'h07},
    {6'h00, 1'b1, 6'h00},
    {6'h2A, 1'b0, 6'h00},
    {6'h15, 1'b0, 6'h2A},
    {6'h00, 1'b0, 6'h3F},
    {6'h00, 1'b0, 6'h3F}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NB-1:0] btn_lvl = '0;
  logic          req_clr = 1'b0;
  logic [NB-1:0] req_flag;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 1'b0;

  always #2.5 clk = ~clk;

  btn_req_latch #(.N_BTN(NB)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .btn_lvl  (btn_lvl),
    .req_clr  (req_clr),
    .req_flag (req_flag)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [NB-1:0] exp);
    n_checks++;
    if (req_flag !== exp) begin
      n_fails++;
      $display("FAIL %s: req_flag=%h expected=%h", tag, req_flag, exp);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not finish, got=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    step(); step(); step();
    check("R1 reset state", 6'h00);
    rst = 1'b0;
    step(); step();
    check("R1 idle after reset", 6'h00);

    // R2 R3 R4 R5 R6 R7 R8 vector walk
    for (int k = 0; k < NV; k++) begin
      btn_lvl = VEC[k][12:7];
      req_clr = VEC[k][6];
      step();
      check($sformatf("R2/R3/R4/R5/R6/R7/R8 vector %0d", k), VEC[k][5:0]);
    end

    // R1: reset with buttons held, then held button seen as fresh press
    btn_lvl = 6'h3F;
    req_clr = 1'b0;
    rst = 1'b1;
    step();
    check("R1 flags cleared by reset", 6'h00);
    step(); step();
    rst = 1'b0;
    step();
    check("R1 no request one cycle after reset", 6'h00);
    step();
    check("R1 held button counts as fresh press", 6'h3F);

    // R3: clear while held, flag stays down
    req_clr = 1'b1;
    step();
    check("R5 clear with buttons held", 6'h00);
    req_clr = 1'b0;
    step();
    check("R3 no retrigger while held", 6'h00);
    step();
    check("R3 still no retrigger", 6'h00);

    // R8: release everything, no request from falling edges
    btn_lvl = 6'h00;
    step(); step();
    check("R8 release gives no request", 6'h00);

    // R7: single ring press leaves other bits alone
    btn_lvl = 6'h20;
    step(); step();
    check("R7 ring bit alone", 6'h20);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end
endmodule